// File: doc/BRIEF.md
# Alphanumeric Candidate String Generator

This block produces candidate messages for a brute-force hashing pipeline. Each accepted request yields the next string in a fixed enumeration over a 62-symbol alphabet: lowercase letters, then uppercase letters, then decimal digits. The enumeration visits every string of length 1 first, then every string of length 2, and so on up to a parameterised maximum length. Internally it is a base-62 odometer of variable length. Position 0 is the least significant digit and is also the first byte of the string. When every digit rolls over, the string grows by one character.

A consumer raises `next_req` while `next_ready` is high. One cycle after the request is accepted, `cand_valid` pulses for one cycle. During that pulse, `cand_bytes` and `cand_len` hold the new string. When the enumeration is used up, the block enters a terminal state. In that state `exhausted` is high, no further string is emitted, and all requests are ignored until a synchronous reset. An optional stage, selected by the parameter `PAD_EN`, also presents the string as a 64-byte hash input block with the usual message padding.

The controller has three states:
- `GEN_IDLE`: ready for a request.
- `GEN_SHOW`: the new string is presented.
- `GEN_DONE`: the enumeration is exhausted.

Its transitions are:
- `GEN_IDLE` to `GEN_SHOW`, when a request arrives and the odometer can advance.
- `GEN_IDLE` to `GEN_DONE`, when a request arrives while every digit is at 61 and the length is at its maximum.
- `GEN_SHOW` back to `GEN_IDLE`, unconditionally after one cycle.
- `GEN_DONE` to itself, until reset.

Top module: `alnum_cand_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to a length of 0 with `exhausted` low, `cand_valid` low and `next_ready` high.
- R2: The first request accepted after reset produces the one-character string "a" (byte 0x61), with `cand_len` equal to 1.
- R3: Each symbol index maps to a character: indices 0 to 25 give 'a' to 'z', 26 to 51 give 'A' to 'Z', and 52 to 61 give '0' to '9'. String position p drives `cand_bytes[8p+7:8p]`, so position 0 is the first byte.
- R4: On a request, positions are scanned from 0 upward. The first position whose index is below 61 is incremented. Every lower position that held 61 becomes 0. The length is unchanged.
- R5: If every position holds 61, or the length is 0, the length grows by one and all positions, including the new one, hold index 0.
- R6: A request is accepted only when `next_ready` is high. `cand_valid` is high for exactly the one cycle after acceptance. `next_ready` is low during that cycle.
- R7: Byte lanes at positions at or beyond the current length read 0x00.
- R8: When a request needs growth beyond `MAX_LEN`, no string is emitted. From then on, `exhausted` stays high, `cand_len` reads 0, all bytes read 0x00, `next_ready` stays low, and further requests change no output.
- R9: With `PAD_EN` set, `pad_block` byte j sits at bits [8j+7:8j]. Bytes below the length carry the string, the byte at the length is 0x80, and the other bytes are 0x00. Bytes 56 to 63 then take 8 times the length as a 64-bit little-endian value, and this length field overrides any other content of those bytes.
- R10: A synchronous reset clears `exhausted` and restarts the enumeration, so the next request again yields "a".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| next_req | input | 1 | Request for the next candidate |
| next_ready | output | 1 | High when a request can be accepted |
| cand_valid | output | 1 | One-cycle strobe marking a new candidate |
| cand_bytes | output | MAX_LEN*8 | Candidate characters, position 0 in the low byte |
| cand_len | output | $clog2(MAX_LEN+1) | Candidate length, 0 when exhausted |
| exhausted | output | 1 | Enumeration finished |
| pad_block | output | 512 | Padded 64-byte hash input block (all zero when PAD_EN is 0) |

## Verification
The symbol indices drive the byte lanes through combinational mapping alone. A wrong digit, a missed carry or a wrong length therefore appears on `cand_bytes`, `cand_len` and `pad_block` in the same cycle as the faulty strobe. A wrong controller state appears at once in the handshake: a strobe without a request, a strobe held for two cycles, or `next_ready` asserted while exhausted. Because the reference model follows every string across full rollovers and the terminal request, a carry or growth fault is caught at the first string that depends on it.

// File: rtl/alnum_pkg.sv
package alnum_pkg;

    localparam int SYM_W    = 6;
    localparam int SYM_LAST = 61;

    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_SHOW = 2'd1,
        GEN_DONE = 2'd2
    } gen_state_e;

    function automatic logic [7:0] sym_to_char(input logic [SYM_W-1:0] sym);
        logic [7:0] wide;
        wide = {2'b00, sym};
        if (wide < 8'd26)
            return 8'h61 + wide;
        else if (wide < 8'd52)
            return 8'h41 + (wide - 8'd26);
        else
            return 8'h30 + (wide - 8'd52);
    endfunction

endpackage

// File: rtl/alnum_odometer.sv
module alnum_odometer
    import alnum_pkg::*;
#(
    parameter int MAX_LEN = 58,
    localparam int LW = $clog2(MAX_LEN + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      step,
    output logic [MAX_LEN*SYM_W-1:0]  idx_flat,
    output logic [LW-1:0]             len,
    output logic                      at_end
);

    logic [SYM_W-1:0] idx_q [MAX_LEN];
    logic [SYM_W-1:0] idx_d [MAX_LEN];
    logic [LW-1:0]    len_q;
    logic [LW-1:0]    len_d;
    logic             carry;

    always_comb begin
        carry = 1'b1;
        len_d = len_q;
        for (int p = 0; p < MAX_LEN; p++) begin
            idx_d[p] = idx_q[p];
            if (p < int'(len_q) && carry) begin
                if (idx_q[p] == SYM_W'(SYM_LAST)) begin
                    idx_d[p] = '0;
                end else begin
                    idx_d[p] = idx_q[p] + 1'b1;
                    carry    = 1'b0;
                end
            end
        end
        at_end = carry && (int'(len_q) == MAX_LEN);
        if (carry && !at_end) begin
            for (int p = 0; p < MAX_LEN; p++) begin
                if (p == int'(len_q))
                    idx_d[p] = '0;
            end
            len_d = len_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            for (int p = 0; p < MAX_LEN; p++)
                idx_q[p] <= '0;
        end else if (step && !at_end) begin
            len_q <= len_d;
            for (int p = 0; p < MAX_LEN; p++)
                idx_q[p] <= idx_d[p];
        end
    end

    generate
        for (genvar g = 0; g < MAX_LEN; g++) begin : g_flat
            assign idx_flat[g*SYM_W +: SYM_W] = idx_q[g];

            assert_digit_range_R3: assert property (@(posedge clk) disable iff (rst)
                idx_q[g] <= SYM_W'(SYM_LAST));
        end
    endgenerate

    assign len = len_q;

    assert_len_bound_R8: assert property (@(posedge clk) disable iff (rst)
        int'(len_q) <= MAX_LEN);

    // R4/R5: the length never shrinks and grows by at most one per step
    assert_len_growth_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (len_q == $past(len_q) || len_q == $past(len_q) + 1'b1));

endmodule

// File: rtl/alnum_charmap.sv
module alnum_charmap
    import alnum_pkg::*;
#(
    parameter int MAX_LEN = 58,
    localparam int LW = $clog2(MAX_LEN + 1)
) (
    input  logic [MAX_LEN*SYM_W-1:0] idx_flat,
    input  logic [LW-1:0]            eff_len,
    output logic [MAX_LEN*8-1:0]     bytes
);

    generate
        for (genvar g = 0; g < MAX_LEN; g++) begin : g_lane
            always_comb begin
                if (g < int'(eff_len))
                    bytes[g*8 +: 8] = sym_to_char(idx_flat[g*SYM_W +: SYM_W]);
                else
                    bytes[g*8 +: 8] = 8'h00;
            end
        end
    endgenerate

endmodule

// File: rtl/alnum_pad.sv
module alnum_pad #(
    parameter int MAX_LEN = 58,
    parameter bit PAD_EN  = 1'b1,
    localparam int LW = $clog2(MAX_LEN + 1),
    localparam int BLK_BYTES = 64,
    localparam int LEN_FIELD = 56
) (
    input  logic [MAX_LEN*8-1:0]     bytes,
    input  logic [LW-1:0]            eff_len,
    output logic [BLK_BYTES*8-1:0]   block
);

    logic [63:0] bit_len;

    assign bit_len = {{(61 - LW){1'b0}}, eff_len, 3'b000};

    generate
        if (PAD_EN) begin : g_pad
            for (genvar j = 0; j < BLK_BYTES; j++) begin : g_byte
                if (j >= LEN_FIELD) begin : g_len
                    assign block[j*8 +: 8] = bit_len[(j - LEN_FIELD)*8 +: 8];
                end else if (j < MAX_LEN) begin : g_data
                    always_comb begin
                        if (j < int'(eff_len))
                            block[j*8 +: 8] = bytes[j*8 +: 8];
                        else if (j == int'(eff_len))
                            block[j*8 +: 8] = 8'h80;
                        else
                            block[j*8 +: 8] = 8'h00;
                    end
                end else begin : g_tail
                    assign block[j*8 +: 8] = (j == int'(eff_len)) ? 8'h80 : 8'h00;
                end
            end
        end else begin : g_nopad
            assign block = '0;
        end
    endgenerate

endmodule

// File: rtl/alnum_cand_gen.sv
module alnum_cand_gen
    import alnum_pkg::*;
#(
    parameter int MAX_LEN = 58,
    parameter bit PAD_EN  = 1'b1,
    localparam int LW = $clog2(MAX_LEN + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  next_req,
    output logic                  next_ready,
    output logic                  cand_valid,
    output logic [MAX_LEN*8-1:0]  cand_bytes,
    output logic [LW-1:0]         cand_len,
    output logic                  exhausted,
    output logic [511:0]          pad_block
);

    gen_state_e               state_q;
    gen_state_e               state_d;
    logic                     step;
    logic                     at_end;
    logic [LW-1:0]            len;
    logic [LW-1:0]            eff_len;
    logic [MAX_LEN*SYM_W-1:0] idx_flat;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= GEN_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        step       = 1'b0;
        next_ready = 1'b0;
        cand_valid = 1'b0;
        exhausted  = 1'b0;
        unique case (state_q)
            GEN_IDLE: begin
                next_ready = 1'b1;
                if (next_req) begin
                    if (at_end) begin
                        state_d = GEN_DONE;
                    end else begin
                        step    = 1'b1;
                        state_d = GEN_SHOW;
                    end
                end
            end
            GEN_SHOW: begin
                cand_valid = 1'b1;
                state_d    = GEN_IDLE;
            end
            GEN_DONE: begin
                exhausted = 1'b1;
            end
            default: begin
                state_d = GEN_IDLE;
            end
        endcase
    end

    alnum_odometer #(.MAX_LEN(MAX_LEN)) u_odo (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .idx_flat (idx_flat),
        .len      (len),
        .at_end   (at_end)
    );

    assign eff_len  = exhausted ? '0 : len;
    assign cand_len = eff_len;

    alnum_charmap #(.MAX_LEN(MAX_LEN)) u_map (
        .idx_flat (idx_flat),
        .eff_len  (eff_len),
        .bytes    (cand_bytes)
    );

    alnum_pad #(.MAX_LEN(MAX_LEN), .PAD_EN(PAD_EN)) u_pad (
        .bytes   (cand_bytes),
        .eff_len (eff_len),
        .block   (pad_block)
    );

    assert_valid_after_accept_R6: assert property (@(posedge clk) disable iff (rst)
        cand_valid |-> $past(next_req && next_ready));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        cand_valid |=> !cand_valid);

    assert_exhausted_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        exhausted |=> exhausted);

    assert_exhausted_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        exhausted |-> (!next_ready && !cand_valid && cand_len == '0));

    assert_strobe_has_length_R7: assert property (@(posedge clk) disable iff (rst)
        cand_valid |-> (cand_len != '0 && cand_bytes[7:0] != 8'h00));

    generate
        if (PAD_EN && MAX_LEN < 56) begin : g_pad_chk
            assert_pad_marker_R9: assert property (@(posedge clk) disable iff (rst)
                cand_valid |-> pad_block[8*cand_len +: 8] == 8'h80);
        end
    endgenerate

endmodule

// File: tb/alnum_cand_gen_tb.sv
module alnum_cand_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAXL = 2;
    localparam int LW = $clog2(MAXL + 1);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               next_req = 1'b0;
    logic               next_ready;
    logic               cand_valid;
    logic [MAXL*8-1:0]  cand_bytes;
    logic [LW-1:0]      cand_len;
    logic               exhausted;
    logic [511:0]       pad_block;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int digs[$];
    int mlen;
    int mst;
    int strings_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    alnum_cand_gen #(.MAX_LEN(MAXL), .PAD_EN(1'b1)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .next_req   (next_req),
        .next_ready (next_ready),
        .cand_valid (cand_valid),
        .cand_bytes (cand_bytes),
        .cand_len   (cand_len),
        .exhausted  (exhausted),
        .pad_block  (pad_block)
    );

    function automatic int chr(input int i);
        if (i < 26) return 97 + i;
        if (i < 52) return 65 + i - 26;
        return 48 + i - 52;
    endfunction

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_wide(input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s pad_block: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int el;
        logic [MAXL*8-1:0] eb;
        logic [511:0] ep;
        longint bl;
        el = (mst == 2) ? 0 : mlen;
        eb = '0;
        for (int p = 0; p < MAXL; p++)
            if (p < el) eb[8*p +: 8] = 8'(chr(digs[p]));
        ep = '0;
        bl = 8 * el;
        for (int j = 0; j < 64; j++) begin
            if (j >= 56) ep[8*j +: 8] = 8'((bl >> (8*(j-56))) & 255);
            else if (j < el) ep[8*j +: 8] = eb[8*j +: 8];
            else if (j == el) ep[8*j +: 8] = 8'h80;
        end
        check("R6", "handshake {ready,valid}", {next_ready, cand_valid}, {mst == 0, mst == 1});
        check("R8", "exhausted", exhausted, mst == 2);
        check("R5", "cand_len", cand_len, el);
        check("R3", "cand_bytes", cand_bytes, eb);
        check_wide("R9", pad_block, ep);
    endtask

    task automatic model_step(input bit r);
        bit carry;
        if (r && mst == 0) begin
            carry = 1'b1;
            for (int p = 0; p < mlen; p++) begin
                if (carry) begin
                    if (digs[p] == 61) digs[p] = 0;
                    else begin digs[p] = digs[p] + 1; carry = 1'b0; end
                end
            end
            if (carry && mlen == MAXL) begin
                mst = 2;
            end else begin
                if (carry) begin
                    for (int p = 0; p < mlen; p++) digs[p] = 0;
                    digs.push_back(0);
                    mlen++;
                end
                mst = 1;
                strings_seen++;
            end
        end else if (mst == 1) begin
            mst = 0;
        end
    endtask

    task automatic cycle(input bit r);
        next_req = r;
        @(posedge clk);
        model_step(r);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        next_req = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        digs.delete();
        mlen = 0;
        mst = 0;
        strings_seen = 0;
        check("R1", "len after reset", cand_len, 0);
        check("R1", "valid after reset", cand_valid, 0);
        check("R1", "ready after reset", next_ready, 1);
        check("R1", "exhausted after reset", exhausted, 0);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c;
        @(negedge clk);
        do_reset();

        // R2: first string is "a"
        cycle(1'b1);
        check("R2", "first byte", cand_bytes[7:0], 8'h61);
        check("R2", "first length", cand_len, 1);
        check("R6", "strobe after accept", cand_valid, 1);
        cycle(1'b1);
        check("R6", "strobe drops", cand_valid, 0);

        // run partway, then reset mid-run (R10)
        for (int k = 0; k < 40; k++) cycle(1'b1);
        do_reset();
        cycle(1'b1);
        check("R10", "restart byte", cand_bytes[7:0], 8'h61);
        check("R10", "restart length", cand_len, 1);

        // full enumeration with mixed request patterns
        c = 0;
        while (mst != 2 && c < 20000) begin
            cycle((c % 7) != 3 && (c % 11) != 5);
            if (cand_valid && strings_seen == 62) begin
                check("R3", "last single char '9'", cand_bytes[7:0], 8'h39);
                check("R7", "unused lane zero", cand_bytes[15:8], 8'h00);
            end
            if (cand_valid && strings_seen == 63) begin
                check("R5", "grown string byte0", cand_bytes[7:0], 8'h61);
                check("R5", "grown string byte1", cand_bytes[15:8], 8'h61);
            end
            if (cand_valid && strings_seen == 64)
                check("R4", "increment pos0", cand_bytes[15:0], 16'h6162);
            if (cand_valid && strings_seen == 63 + 62)
                check("R4", "carry into pos1", cand_bytes[15:0], 16'h6261);
            c++;
        end
        check("R8", "enumeration count", strings_seen, 62 + 62*62);
        check("R8", "reached exhaustion", exhausted, 1);

        // R8: requests ignored while exhausted
        for (int k = 0; k < 12; k++) cycle(k % 2 == 0);
        check("R8", "still exhausted", exhausted, 1);
        check("R8", "bytes quiet", cand_bytes, 0);

        // R10: reset clears exhaustion
        do_reset();
        cycle(1'b1);
        check("R10", "exhausted cleared", exhausted, 0);
        check("R10", "first byte again", cand_bytes[7:0], 8'h61);
        cycle(1'b0);
        cycle(1'b0);

        finish_run();
    end

endmodule